// File: doc/BRIEF.md
# Address Window Switch Controller

This block steers a host-side address window onto one of several internal cores before an access is made to it. A client presents an access (read or write) together with a core index. When that core is not the one the window currently points at, the controller computes the window base for the index, writes it to the window register, reads the register back and converts the value back into an index. The access goes ahead only if the two indices agree. A mismatch causes a fixed back-off, then another write and readback round, until a bounded number of rounds has been used up.

The controller remembers which core the window holds after a confirmed switch, so later accesses to that core go straight to the data port. When a switch fails, the access completes with a failure flag. A failed read returns all ones and a failed write never reaches the data port. The window register and the data target are both reached over simple request/acknowledge ports. The window port also carries an error flag, and an error ends the switch at once.

Top module: `wsw_window_switch`

## Requirements
- R1: The value written to the window register is `ENUM_BASE + core * CORE_SIZE`, with defaults ENUM_BASE = 0x1800_0000 and CORE_SIZE = 0x1000, so core 0 gives 0x1800_0000 and core 15 gives 0x1800_F000.
- R2: After each window write, the register is read back and converted to `(value - ENUM_BASE) / CORE_SIZE`, and a readback below ENUM_BASE never matches. The switch is confirmed only when this index equals the requested core, and the data access is then issued.
- R3: After a mismatching readback, the window port stays idle for exactly RETRY_DELAY clock cycles (default 1250) before the next window write is requested.
- R4: A switch makes at most MAX_RETRY + 2 write/readback rounds (5 by default). If the readback matches in the last allowed round the access succeeds. If that round also mismatches the access fails, and no further window write is made.
- R5: A window response with `win_err` high, on either the write or the readback, ends the switch at once with a failure and no further window request.
- R6: An access to the core recorded as mapped makes no window request at all and goes directly to the data port.
- R7: A failed access completes with `acc_fail` high. For a read, `acc_rdata` is all ones. For a write, no request is made on the data port.
- R8: After reset no core is recorded as mapped (`mapped_valid` low). The record changes only when a readback confirms a switch, and a failed switch leaves the previous record in place.
- R9: `busy` is high while window writes, readbacks or back-off are in progress, and low in all other cycles, including the whole data phase. `acc_ready` is high only when no access is in progress.
- R10: Each accepted access produces exactly one `acc_done` pulse of one cycle, with `acc_fail` and `acc_rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request, taken when `acc_ready` is high |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_core | input | IDX_W | Target core index |
| acc_addr | input | ADDR_W | Offset inside the core's window |
| acc_wdata | input | DATA_W | Write data |
| acc_ready | output | 1 | Controller idle, able to take an access |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_fail | output | 1 | Completion was a failed switch |
| acc_rdata | output | DATA_W | Read data, all ones on failure |
| busy | output | 1 | Window switch in progress |
| mapped_core | output | IDX_W | Core the window is recorded to hold |
| mapped_valid | output | 1 | `mapped_core` is meaningful |
| win_req | output | 1 | Window register access request |
| win_we | output | 1 | 1 = window write, 0 = window readback |
| win_wdata | output | WIN_W | Window base value being written |
| win_ack | input | 1 | Window access acknowledge |
| win_err | input | 1 | Window access error, valid with `win_ack` |
| win_rdata | input | WIN_W | Window readback value, valid with `win_ack` |
| dat_req | output | 1 | Data access request |
| dat_we | output | 1 | Data write enable |
| dat_addr | output | ADDR_W | Data offset |
| dat_wdata | output | DATA_W | Data write value |
| dat_ack | input | 1 | Data access acknowledge |
| dat_rdata | input | DATA_W | Data read value, valid with `dat_ack` |

## Verification
The bench models a window register that can be set to drop a chosen number of writes or to signal an error on the next write or readback. It targets the retry boundary: a match in the fifth round must succeed, and five dropped rounds must fail after exactly five writes. A design that counted rounds one off in either direction would issue a data access it should have refused, or refuse one it should have allowed. Back-off gaps are measured cycle by cycle, so a timer that expired early or late shows up. After a readback error has moved the window, the bench returns to the previously recorded core to show that the record was not updated, and that the skip path then uses the window as it stands. Failed reads must return all ones and failed writes must not appear on the data port.

// File: rtl/wsw_pkg.sv
// Shared types for the address window switch controller.
package wsw_pkg;

    // Controller states; the switch phases are WIN_WR, WIN_RD and BACKOFF.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN_WR,
        ST_WIN_RD,
        ST_BACKOFF,
        ST_DATA
    } wsw_state_e;

endpackage

// File: rtl/wsw_window_map.sv
// Window address arithmetic.
// Forms the window base for a requested core index and checks whether a
// readback value decodes to that same index. Purely combinational.
// Assumes CORE_SIZE > 0; a power-of-two stride uses a shift, any other a divide.
module wsw_window_map #(
    parameter int unsigned              IDX_W     = 4,
    parameter int unsigned              WIN_W     = 32,
    parameter int unsigned              CORE_SIZE = 4096,
    parameter logic [WIN_W-1:0]         ENUM_BASE = 32'h1800_0000
) (
    input  logic [IDX_W-1:0] req_idx,
    input  logic [WIN_W-1:0] rb_value,
    output logic [WIN_W-1:0] win_value,
    output logic             rb_match
);
    localparam bit              IS_POW2 = ((CORE_SIZE & (CORE_SIZE - 1)) == 0);
    localparam int unsigned     SHIFT   = $clog2(CORE_SIZE);
    localparam logic [WIN_W-1:0] STRIDE = WIN_W'(CORE_SIZE);

    logic [WIN_W-1:0] req_wide;
    logic [WIN_W-1:0] rb_offset;
    logic [WIN_W-1:0] rb_index;
    logic             rb_above;

    // Base value for the requested core.
    always_comb begin
        req_wide  = WIN_W'(req_idx);
        win_value = ENUM_BASE + (req_wide * STRIDE);
    end

    // Offset of the readback above the enumeration base.
    always_comb begin
        rb_above  = (rb_value >= ENUM_BASE);
        rb_offset = rb_value - ENUM_BASE;
    end

    // Index from offset: shift for power-of-two strides, divide otherwise.
    generate
        if (IS_POW2) begin : g_shift
            always_comb rb_index = rb_offset >> SHIFT;
        end else begin : g_div
            always_comb rb_index = rb_offset / STRIDE;
        end
    endgenerate

    // Readback matches only above the base and at the same index.
    always_comb rb_match = rb_above && (rb_index == req_wide);

endmodule

// File: rtl/wsw_retry_timer.sv
// Back-off timer between switch attempts.
// Loaded by `start`, it counts while `run` is high and raises `expire`
// in the DELAY-th cycle of running. Assumes DELAY >= 1.
module wsw_retry_timer #(
    parameter int unsigned DELAY = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(DELAY + 1);

    logic [CW-1:0] remain_q;

    // Count down the remaining back-off cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= CW'(DELAY - 1);
        end else if (run && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Expiry once the count has run out while waiting.
    always_comb expire = run && (remain_q == '0);

    generate
        if (DELAY > 1) begin : g_min_gap
            // R3: a freshly started back-off never ends in the next cycle.
            p_backoff_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> !expire);
        end
    endgenerate

endmodule

// File: rtl/wsw_switch_ctrl.sv
// Sequencer for window switching and the following data access.
// Takes one access at a time. It skips the switch when the core is already
// mapped, otherwise it runs bounded write/readback rounds with back-off,
// then issues the data access or completes with a failure.
// Assumes the window and data ports hold their acknowledges for one cycle.
module wsw_switch_ctrl
    import wsw_pkg::*;
#(
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MAX_RETRY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_core,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              acc_done,
    output logic              acc_fail,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              busy,
    output logic [IDX_W-1:0]  mapped_core,
    output logic              mapped_valid,
    output logic [IDX_W-1:0]  req_idx,
    input  logic              rb_match,
    output logic              win_req,
    output logic              win_we,
    input  logic              win_ack,
    input  logic              win_err,
    output logic              tmr_start,
    output logic              tmr_run,
    input  logic              tmr_expire,
    output logic              dat_req,
    output logic              dat_we,
    output logic [ADDR_W-1:0] dat_addr,
    output logic [DATA_W-1:0] dat_wdata,
    input  logic              dat_ack,
    input  logic [DATA_W-1:0] dat_rdata
);
    localparam int unsigned      TW        = $clog2(MAX_RETRY + 2) + 1;
    localparam logic [TW-1:0]    TRY_LIMIT = TW'(MAX_RETRY);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    wsw_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TW-1:0]     tries_q;
    logic [IDX_W-1:0]  map_q;
    logic              map_vld_q;
    logic              done_q;
    logic              fail_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_ok;
    logic              rd_bad;
    logic              give_up;

    // Readback outcome decode for the current round.
    always_comb begin
        rd_ok   = (st_q == ST_WIN_RD) && win_ack && !win_err && rb_match;
        rd_bad  = (st_q == ST_WIN_RD) && win_ack && !win_err && !rb_match;
        give_up = (tries_q > TRY_LIMIT);
    end

    // Main sequencer: request capture, switch rounds, data phase, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            idx_q     <= '0;
            we_q      <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            tries_q   <= '0;
            map_q     <= '0;
            map_vld_q <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        idx_q   <= acc_core;
                        we_q    <= acc_we;
                        addr_q  <= acc_addr;
                        wdata_q <= acc_wdata;
                        tries_q <= '0;
                        if (map_vld_q && (acc_core == map_q)) begin
                            st_q <= ST_DATA;
                        end else begin
                            st_q <= ST_WIN_WR;
                        end
                    end
                end
                ST_WIN_WR: begin
                    if (win_ack) begin
                        if (win_err) begin
                            done_q  <= 1'b1;
                            fail_q  <= 1'b1;
                            rdata_q <= ALL_ONES;
                            st_q    <= ST_IDLE;
                        end else begin
                            st_q <= ST_WIN_RD;
                        end
                    end
                end
                ST_WIN_RD: begin
                    if (rd_ok) begin
                        map_q     <= idx_q;
                        map_vld_q <= 1'b1;
                        st_q      <= ST_DATA;
                    end else if (win_ack && (win_err || give_up)) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        rdata_q <= ALL_ONES;
                        st_q    <= ST_IDLE;
                    end else if (rd_bad) begin
                        tries_q <= tries_q + 1'b1;
                        st_q    <= ST_BACKOFF;
                    end
                end
                ST_BACKOFF: begin
                    if (tmr_expire) begin
                        st_q <= ST_WIN_WR;
                    end
                end
                ST_DATA: begin
                    if (dat_ack) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b0;
                        rdata_q <= dat_rdata;
                        st_q    <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port drives derived from state and captured request.
    always_comb begin
        acc_ready    = (st_q == ST_IDLE);
        acc_done     = done_q;
        acc_fail     = fail_q;
        acc_rdata    = rdata_q;
        busy         = (st_q == ST_WIN_WR) || (st_q == ST_WIN_RD) || (st_q == ST_BACKOFF);
        mapped_core  = map_q;
        mapped_valid = map_vld_q;
        req_idx      = idx_q;
        win_req      = (st_q == ST_WIN_WR) || (st_q == ST_WIN_RD);
        win_we       = (st_q == ST_WIN_WR);
        tmr_start    = rd_bad && !give_up;
        tmr_run      = (st_q == ST_BACKOFF);
        dat_req      = (st_q == ST_DATA);
        dat_we       = we_q;
        dat_addr     = addr_q;
        dat_wdata    = wdata_q;
    end

    // R1: a window request stays up until it is acknowledged.
    p_win_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && !win_ack) |=> win_req);

    // R5: an error response ends all window traffic for this access.
    p_err_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && win_ack && win_err) |=> (!win_req && acc_done && acc_fail));

    // R7: a failed completion returns all ones.
    p_fail_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && acc_fail) |-> (acc_rdata == ALL_ONES));

    // R8: the mapped record moves only after a confirming readback.
    p_map_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mapped_core != $past(mapped_core)) || $rose(mapped_valid))
            |-> $past(win_req && !win_we && win_ack && !win_err && rb_match));

    // R9: no data access while a switch is in progress.
    p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dat_req);

    // R10: completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

endmodule

// File: rtl/wsw_window_switch.sv
// Address window switch controller, top level.
// Connects the sequencer, the window address arithmetic and the back-off timer.
// Assumes one client; arbitration between requesters sits outside.
module wsw_window_switch #(
    parameter int unsigned      IDX_W       = 4,
    parameter int unsigned      ADDR_W      = 12,
    parameter int unsigned      DATA_W      = 32,
    parameter int unsigned      WIN_W       = 32,
    parameter int unsigned      CORE_SIZE   = 4096,
    parameter logic [WIN_W-1:0] ENUM_BASE   = 32'h1800_0000,
    parameter int unsigned      MAX_RETRY   = 3,
    parameter int unsigned      RETRY_DELAY = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_core,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              acc_done,
    output logic              acc_fail,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              busy,
    output logic [IDX_W-1:0]  mapped_core,
    output logic              mapped_valid,
    output logic              win_req,
    output logic              win_we,
    output logic [WIN_W-1:0]  win_wdata,
    input  logic              win_ack,
    input  logic              win_err,
    input  logic [WIN_W-1:0]  win_rdata,
    output logic              dat_req,
    output logic              dat_we,
    output logic [ADDR_W-1:0] dat_addr,
    output logic [DATA_W-1:0] dat_wdata,
    input  logic              dat_ack,
    input  logic [DATA_W-1:0] dat_rdata
);
    logic [IDX_W-1:0] req_idx;
    logic             rb_match;
    logic             tmr_start;
    logic             tmr_run;
    logic             tmr_expire;

    wsw_switch_ctrl #(
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAX_RETRY (MAX_RETRY)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_we       (acc_we),
        .acc_core     (acc_core),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata),
        .acc_ready    (acc_ready),
        .acc_done     (acc_done),
        .acc_fail     (acc_fail),
        .acc_rdata    (acc_rdata),
        .busy         (busy),
        .mapped_core  (mapped_core),
        .mapped_valid (mapped_valid),
        .req_idx      (req_idx),
        .rb_match     (rb_match),
        .win_req      (win_req),
        .win_we       (win_we),
        .win_ack      (win_ack),
        .win_err      (win_err),
        .tmr_start    (tmr_start),
        .tmr_run      (tmr_run),
        .tmr_expire   (tmr_expire),
        .dat_req      (dat_req),
        .dat_we       (dat_we),
        .dat_addr     (dat_addr),
        .dat_wdata    (dat_wdata),
        .dat_ack      (dat_ack),
        .dat_rdata    (dat_rdata)
    );

    wsw_window_map #(
        .IDX_W     (IDX_W),
        .WIN_W     (WIN_W),
        .CORE_SIZE (CORE_SIZE),
        .ENUM_BASE (ENUM_BASE)
    ) u_map (
        .req_idx   (req_idx),
        .rb_value  (win_rdata),
        .win_value (win_wdata),
        .rb_match  (rb_match)
    );

    wsw_retry_timer #(
        .DELAY (RETRY_DELAY)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .expire (tmr_expire)
    );

endmodule

// File: tb/wsw_window_switch_test.sv
// Scoreboard bench for the window switch controller.
module wsw_window_switch_test;
    localparam int unsigned MAXR  = 3;
    localparam int unsigned DLY   = 1250;
    localparam logic [31:0] BASE  = 32'h1800_0000;
    localparam logic [31:0] SIZE  = 32'h0000_1000;
    localparam int unsigned ROUNDS = MAXR + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_we = 1'b0;
    logic [3:0]  acc_core = '0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, acc_done, acc_fail, busy, mapped_valid;
    logic [31:0] acc_rdata;
    logic [3:0]  mapped_core;
    logic        win_req, win_we, dat_req, dat_we;
    logic [31:0] win_wdata, dat_wdata;
    logic [11:0] dat_addr;
    logic        win_ack = 1'b0, win_err = 1'b0, dat_ack = 1'b0;
    logic [31:0] win_rdata = '0, dat_rdata = '0;

    always #4 clk = ~clk;  // 125 MHz

    wsw_window_switch uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_core(acc_core),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .acc_done(acc_done), .acc_fail(acc_fail),
        .acc_rdata(acc_rdata), .busy(busy),
        .mapped_core(mapped_core), .mapped_valid(mapped_valid),
        .win_req(win_req), .win_we(win_we), .win_wdata(win_wdata),
        .win_ack(win_ack), .win_err(win_err), .win_rdata(win_rdata),
        .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr),
        .dat_wdata(dat_wdata), .dat_ack(dat_ack), .dat_rdata(dat_rdata)
    );

    typedef struct {
        string       tag;
        bit          we;
        bit          fail;
        logic [31:0] rdata;
        logic [31:0] wdata;
        int          wins;
        int          dwrites;
        logic [31:0] last_win;
        logic [3:0]  map;
        bit          mvld;
    } exp_t;

    exp_t        sb[$];
    int          n_cmp = 0, n_bad = 0, done_cnt = 0;

    // Window register model with fault injection.
    logic [31:0] win_reg = 32'h0;
    int          ign_cnt = 0;
    int          err_mode = 0;   // 1: error on next write, 2: on next readback
    int          ww_cnt = 0, dwr_cnt = 0;
    logic [31:0] last_ww = '0, last_dw = '0;
    bit          busy_dat = 0;
    int          gap = 0;

    // Reference state kept by the driver.
    logic [31:0] win_m = 32'h0;
    logic [3:0]  map_m = '0;
    bit          mvld_m = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    // Window port responder.
    always @(posedge clk) begin
        win_ack <= win_req && !win_ack;
        win_err <= 1'b0;
        if (win_req && !win_ack) begin
            if (win_we) begin
                ww_cnt  <= ww_cnt + 1;
                last_ww <= win_wdata;
                if (err_mode == 1) begin
                    win_err  <= 1'b1;
                    err_mode <= 0;
                end else if (ign_cnt > 0) begin
                    ign_cnt <= ign_cnt - 1;
                end else begin
                    win_reg <= win_wdata;
                end
            end else begin
                win_rdata <= win_reg;
                if (err_mode == 2) begin
                    win_err  <= 1'b1;
                    err_mode <= 0;
                end
            end
        end
    end

    // Data port responder: read data tags the current window.
    always @(posedge clk) begin
        dat_ack <= dat_req && !dat_ack;
        if (dat_req && !dat_ack) begin
            if (dat_we) begin
                dwr_cnt <= dwr_cnt + 1;
                last_dw <= dat_wdata;
            end else begin
                dat_rdata <= win_reg ^ {20'h0, dat_addr};
            end
        end
    end

    // Monitor: back-off gaps, busy exclusivity, scoreboard compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && dat_req) busy_dat = 1;
            if (busy && !win_req) begin
                gap++;
            end else if (win_req && gap > 0) begin
                chk(gap == DLY, "R3", "back-off gap", gap, DLY);
                gap = 0;
            end
            if (acc_done) begin
                if (sb.size() == 0) begin
                    chk(0, "R10", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(acc_fail == e.fail, "R4", {e.tag, " fail flag"}, acc_fail, e.fail);
                    if (!e.we)
                        chk(acc_rdata == e.rdata, "R7", {e.tag, " read data"}, acc_rdata, e.rdata);
                    chk(ww_cnt == e.wins, "R4", {e.tag, " window writes"}, ww_cnt, e.wins);
                    chk(dwr_cnt == e.dwrites, "R7", {e.tag, " data writes"}, dwr_cnt, e.dwrites);
                    if (e.dwrites > 0)
                        chk(last_dw == e.wdata, "R2", {e.tag, " write data"}, last_dw, e.wdata);
                    if (e.wins > 0)
                        chk(last_ww == e.last_win, "R1", {e.tag, " window value"}, last_ww, e.last_win);
                    chk({mapped_valid, mapped_core} == {e.mvld, e.map}, "R8",
                        {e.tag, " mapped record"}, {27'h0, mapped_valid, mapped_core}, {27'h0, e.mvld, e.map});
                    chk(!busy_dat, "R9", {e.tag, " busy during data"}, busy_dat, 0);
                end
                done_cnt++;
            end
        end
    end

    // Driver: compute expected outcome, push it, then launch the access.
    task automatic run_acc(input string tag, input int core, input bit we,
                           input logic [11:0] addr, input logic [31:0] wd,
                           input int ign, input int errm);
        exp_t e;
        logic [31:0] tgt;
        int target_cnt;
        tgt = BASE + 32'(core) * SIZE;
        e.tag = tag; e.we = we; e.wdata = wd; e.last_win = tgt;
        if (mvld_m && map_m == 4'(core)) begin
            e.fail = 0; e.wins = 0;
        end else if (errm == 1) begin
            e.fail = 1; e.wins = 1;
        end else if (errm == 2) begin
            e.fail = 1; e.wins = 1; win_m = tgt;
        end else if (ign + 1 <= int'(ROUNDS)) begin
            e.fail = 0; e.wins = ign + 1; win_m = tgt; map_m = 4'(core); mvld_m = 1;
        end else begin
            e.fail = 1; e.wins = ROUNDS;
        end
        e.rdata   = e.fail ? 32'hFFFF_FFFF : (win_m ^ {20'h0, addr});
        e.dwrites = (we && !e.fail) ? 1 : 0;
        e.map = map_m; e.mvld = mvld_m;
        sb.push_back(e);
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        ign_cnt = ign; err_mode = errm; ww_cnt = 0; dwr_cnt = 0; busy_dat = 0; gap = 0;
        target_cnt = done_cnt + 1;
        acc_valid = 1; acc_we = we; acc_core = 4'(core); acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 0;
        while (done_cnt < target_cnt) @(negedge clk);
        @(negedge clk);
        chk(!acc_done, "R10", {tag, " done pulse width"}, acc_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(acc_ready, "R9", "reset ready", acc_ready, 1);
        chk(!busy, "R9", "reset busy", busy, 0);
        chk(!mapped_valid, "R8", "reset mapped", mapped_valid, 0);
        chk(!acc_done, "R10", "reset done", acc_done, 0);
        run_acc("R2 clean switch read",  2, 0, 12'h010, 0, 0, 0);
        run_acc("R6 skip same core",     2, 0, 12'h024, 0, 0, 0);
        run_acc("R2 switch write",       5, 1, 12'h100, 32'hCAFE_0005, 0, 0);
        run_acc("R3 two dropped writes", 3, 0, 12'h044, 0, 2, 0);
        run_acc("R4 last round match",   7, 0, 12'h078, 0, ROUNDS - 1, 0);
        run_acc("R4 rounds exhausted",   9, 0, 12'h090, 0, ROUNDS, 0);
        run_acc("R5 write error",        1, 1, 12'h004, 32'h1234_5678, 0, 1);
        run_acc("R5 readback error",     4, 0, 12'h008, 0, 0, 2);
        run_acc("R8 stale record skip",  7, 0, 12'h00C, 0, 0, 0);
        run_acc("R1 lowest core",        0, 0, 12'hFFF, 0, 0, 0);
        run_acc("R1 highest core",      15, 1, 12'h3A0, 32'h0BAD_F00D, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule